// File: doc/BRIEF.md
# Monitor Channel Handshake Transmitter

This block sends a message of one or more bytes over a frame-based monitor channel. In each frame it drives one data byte and an active-low frame-marker bit (MX). It reads back two things: the acknowledge bit (MR, active low) returned by the far receiver, and the MX level actually present on the shared line. Every decision is taken on a one-cycle frame strobe. Between strobes all outputs hold their values.

A local source presents bytes on `msg_data`, with `msg_valid` marking a usable byte and `msg_last` marking the final byte. A message starts when `msg_req` is high and the channel has been quiet for two frames. The block takes each byte with a one-cycle `msg_pop` pulse. It repeats that byte with MX low in every frame until the receiver acknowledges it. It then releases MX for one frame before the next byte. After the last byte it closes the message by holding MX high for two frames.

A collision on the line, an early acknowledge, or a local abort request stops the message at once. An aborted message waits until the line goes quiet and is then dropped.

Top module: `mon_tx`

## Requirements
- R1: While `rst` is high, and afterwards until a message starts, `mx_out` is 1 and `busy`, `done`, `aborted` and `msg_pop` are 0.
- R2: A message starts only at a strobe where `msg_req` and `msg_valid` are both 1. In addition, both `mx_in` and `mr_in` must have been 1 at that strobe and at the strobe before it.
- R3: At the start strobe, three things happen together: `mx_out` goes to 0, `tx_data` takes the first byte, and `msg_pop` pulses. Bytes leave in the order the source presents them.
- R4: While a byte is being sent, `mx_out` stays 0 and `tx_data` stays unchanged until a strobe samples `mr_in` = 0 outside the byte's first frame. The number of frames with MX low equals the number of frames the receiver waits before acknowledging.
- R5: A strobe where `mx_in` differs from `mx_out` during a message is a collision. It causes an abort. An abort means `aborted` pulses and `mx_out` is 1 from that strobe on.
- R6: An `abort_req` sampled high during a message causes an abort. `abort_req` has no effect when no message is in progress. After an abort, the block becomes idle at the first strobe where `mx_in` and `mr_in` are both 1.
- R7: After the last byte is acknowledged, `mx_out` is 1 for two frames. `done` pulses at the second strobe and `busy` falls at the same time. `done` and `aborted` are never high together.
- R8: Suppose a byte that is not the last one is acknowledged while no next byte is valid. Then `mx_out` stays 1 and `busy` stays 1 until a byte becomes valid. At that strobe the new byte goes out with `mx_out` = 0.
- R9: Suppose the next byte is valid at the strobe that acknowledges the current byte. Then that next byte appears on `tx_data` in the frame where `mx_out` returns to 1, and `mx_out` goes back to 0 after exactly one frame.
- R10: `mr_in` = 0 sampled at the end of a byte's first frame is an acknowledge that came too early. It causes an abort.
- R11: `mx_out`, `tx_data`, `msg_pop`, `done` and `aborted` change only on cycles where `frame_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle pulse at each frame boundary |
| msg_req | input | 1 | Request to send a message |
| msg_valid | input | 1 | `msg_data` holds a byte ready to be taken |
| msg_data | input | DW | Byte offered by the source |
| msg_last | input | 1 | Offered byte is the final one of the message |
| msg_pop | output | 1 | One-cycle pulse: offered byte has been taken |
| abort_req | input | 1 | Local request to abandon the message |
| mx_in | input | 1 | MX level sampled on the line for the ending frame |
| mr_in | input | 1 | Acknowledge bit from the receiver, active low |
| mx_out | output | 1 | MX bit driven for the current frame, active low |
| tx_data | output | DW | Byte driven for the current frame |
| busy | output | 1 | A message or abort recovery is in progress |
| done | output | 1 | One-cycle pulse: message completed |
| aborted | output | 1 | One-cycle pulse: message abandoned |

## Verification
Two situations are hardest to reach from the ports. One is a collision while MX is released between bytes. The other is an acknowledge that arrives in a byte's first frame. Both require line activity in one particular frame. The bench models the receiver with a programmable acknowledge delay, so a delay of one frame produces the early acknowledge. It also models a second station that can pull MX low in any single frame. That station is triggered only after the bench has seen `mx_out` rise in the middle of a message. A source whose byte supply can be held back reaches the stalled-wait case. Holding `mr_in` low before the request shows that the two-quiet-frame start rule is enforced.

// File: rtl/mon_tx.sv
module mon_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_stb,
  input  logic          msg_req,
  input  logic          msg_valid,
  input  logic [DW-1:0] msg_data,
  input  logic          msg_last,
  output logic          msg_pop,
  input  logic          abort_req,
  input  logic          mx_in,
  input  logic          mr_in,
  output logic          mx_out,
  output logic [DW-1:0] tx_data,
  output logic          busy,
  output logic          done,
  output logic          aborted
);

  typedef enum logic [2:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_EOM, ST_ABORT} st_t;

  st_t st;
  logic first_q, last_q, nxt_q, eom_q, quiet_q;

  wire line_quiet = mx_in & mr_in;
  wire in_msg     = (st != ST_IDLE) && (st != ST_ABORT);
  wire early_ack  = (st == ST_SEND) && first_q && !mr_in;
  wire hit_abort  = in_msg && (abort_req || (mx_in != mx_out) || early_ack);

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      mx_out  <= 1'b1;
      tx_data <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      nxt_q   <= 1'b0;
      eom_q   <= 1'b0;
      quiet_q <= 1'b0;
      msg_pop <= 1'b0;
      done    <= 1'b0;
      aborted <= 1'b0;
    end else begin
      msg_pop <= 1'b0;
      done    <= 1'b0;
      aborted <= 1'b0;
      if (frame_stb) begin
        if (hit_abort) begin
          st      <= ST_ABORT;
          mx_out  <= 1'b1;
          aborted <= 1'b1;
          nxt_q   <= 1'b0;
        end else begin
          case (st)
            ST_IDLE: begin
              quiet_q <= line_quiet;
              if (quiet_q && line_quiet && msg_req && msg_valid) begin
                tx_data <= msg_data;
                last_q  <= msg_last;
                msg_pop <= 1'b1;
                mx_out  <= 1'b0;
                first_q <= 1'b1;
                quiet_q <= 1'b0;
                st      <= ST_SEND;
              end
            end
            ST_SEND: begin
              if (!mr_in) begin
                mx_out <= 1'b1;
                if (last_q) begin
                  eom_q <= 1'b0;
                  st    <= ST_EOM;
                end else begin
                  st    <= ST_WAIT;
                  nxt_q <= msg_valid;
                  if (msg_valid) begin
                    tx_data <= msg_data;
                    last_q  <= msg_last;
                    msg_pop <= 1'b1;
                  end
                end
              end else begin
                first_q <= 1'b0;
              end
            end
            ST_WAIT: begin
              if (nxt_q) begin
                nxt_q   <= 1'b0;
                mx_out  <= 1'b0;
                first_q <= 1'b1;
                st      <= ST_SEND;
              end else if (msg_valid) begin
                tx_data <= msg_data;
                last_q  <= msg_last;
                msg_pop <= 1'b1;
                mx_out  <= 1'b0;
                first_q <= 1'b1;
                st      <= ST_SEND;
              end
            end
            ST_EOM: begin
              if (eom_q) begin
                done    <= 1'b1;
                quiet_q <= 1'b0;
                st      <= ST_IDLE;
              end else begin
                eom_q <= 1'b1;
              end
            end
            ST_ABORT: begin
              if (line_quiet) begin
                quiet_q <= 1'b0;
                st      <= ST_IDLE;
              end
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  AST_IDLE_MX_HIGH: assert property (@(posedge clk) disable iff (rst) !busy |-> mx_out); // R1
  AST_START_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($fell(mx_out) && $past(!busy)) |-> $past(mx_in && mr_in && msg_req)); // R2
  AST_REPEAT_BYTE: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && busy && !mx_out && !mx_in && mr_in && !abort_req) |=> (!mx_out && $stable(tx_data))); // R4
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst) aborted |-> mx_out); // R5
  AST_END_EXCL: assert property (@(posedge clk) disable iff (rst) !(done && aborted)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && mx_out)); // R7
  AST_EARLY_ACK: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && early_ack) |=> aborted); // R10
  AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> ($stable(mx_out) && $stable(tx_data) && !msg_pop && !done)); // R11

endmodule

// File: tb/mon_tx_tb_top.sv
module mon_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_CLKS = 4;

  logic clk = 1'b0, rst = 1'b1, frame_stb = 1'b0;
  logic msg_req = 1'b0, abort_req = 1'b0, other_mx = 1'b1, rx_hold = 1'b0, mr_rcv = 1'b1;
  logic msg_valid, msg_last, msg_pop, mx_in, mr_in, mx_out, busy, done, aborted;
  logic [7:0] msg_data, tx_data;
  logic [7:0] msg [8];
  logic [7:0] exp_q [$];
  int msg_len = 0, idx = 0, src_limit = 99, ack_delay = 2, lowcnt = 0;
  int checks = 0, errors = 0, frame_no = 0, div = 0;
  int cur_low = 0, cur_high = 0, rise_fr = 0, done_fr = 0;
  bit chk_len = 1, chk_antic = 1, done_seen = 0, abort_seen = 0, prev_mx = 1, prev_busy = 0;
  event fr_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign msg_data  = msg[idx[2:0]];
  assign msg_valid = (idx < msg_len) && (idx < src_limit);
  assign msg_last  = (idx == msg_len - 1);
  assign mx_in     = mx_out & other_mx;
  assign mr_in     = rx_hold ? 1'b0 : mr_rcv;

  mon_tx #(.DW(8)) dut_i (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .msg_req(msg_req), .msg_valid(msg_valid),
    .msg_data(msg_data), .msg_last(msg_last), .msg_pop(msg_pop), .abort_req(abort_req),
    .mx_in(mx_in), .mr_in(mr_in), .mx_out(mx_out), .tx_data(tx_data), .busy(busy),
    .done(done), .aborted(aborted)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // driver: fills the source and pushes the expected bytes into the scoreboard
  task automatic send_msg(input int n, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    msg[0] = b0; msg[1] = b1; msg[2] = b2;
    for (int i = 0; i < n; i++) exp_q.push_back(msg[i]);
    idx = 0; msg_len = n;
    done_seen = 0; abort_seen = 0;
    msg_req = 1'b1;
  endtask

  task automatic flush();
    exp_q.delete();
    msg_len = 0; idx = 0; msg_req = 1'b0; src_limit = 99;
  endtask

  task automatic wait_end(input int maxf);
    for (int i = 0; i < maxf; i++) begin
      if (done_seen || abort_seen) break;
      @(fr_ev);
    end
    msg_req = 1'b0;
  endtask

  task automatic wait_gap(input int maxf);
    for (int i = 0; i < maxf; i++) begin
      if (busy && mx_out) break;
      @(fr_ev);
    end
  endtask

  // frame generator, receiver model, source and monitor
  always @(negedge clk) begin
    if (frame_stb) begin
      frame_no++;
      lowcnt = (mx_out & other_mx) ? 0 : lowcnt + 1;
      mr_rcv = (lowcnt >= ack_delay) ? 1'b0 : 1'b1;
      if (msg_pop) idx++;
      if (done) begin done_seen = 1; done_fr = frame_no; end
      if (aborted) abort_seen = 1;
      if (prev_mx && !mx_out) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected byte", tx_data, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(tx_data == e, "R3 byte order", tx_data, e);
        end
        if (prev_busy && chk_antic) chk(cur_high == 1, "R9 one release frame", cur_high, 1);
        cur_low = 1;
      end else if (!mx_out) cur_low++;
      if (!prev_mx && mx_out) begin
        rise_fr = frame_no; cur_high = 1;
        if (chk_len) chk(cur_low == ack_delay, "R4 frames held low", cur_low, ack_delay);
        if (chk_antic && busy && exp_q.size() > 0)
          chk(tx_data == exp_q[0], "R9 next byte early", tx_data, exp_q[0]);
      end else if (mx_out) cur_high++;
      prev_mx = mx_out; prev_busy = busy;
      -> fr_ev;
    end
    div = (div == FRAME_CLKS - 1) ? 0 : div + 1;
    frame_stb = (div == 0);
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (6) @(negedge clk);
    chk(mx_out && !busy && !done && !aborted && !msg_pop, "R1 reset state", {mx_out, busy, done, aborted}, 8);
    rst = 1'b0;
    repeat (3) @(fr_ev);
    chk(mx_out && !busy, "R1 idle after reset", {mx_out, busy}, 2);

    // R2: start held off while MR is low, then exactly two quiet frames
    rx_hold = 1'b1;
    repeat (2) @(fr_ev);
    send_msg(1, 8'hA5, 8'h00, 8'h00);
    repeat (4) @(fr_ev);
    chk(!busy && mx_out, "R2 no start on busy line", busy, 0);
    rx_hold = 1'b0;
    @(fr_ev);
    chk(!busy, "R2 one quiet frame not enough", busy, 0);
    @(fr_ev);
    chk(busy && !mx_out, "R3 start after two quiet frames", {busy, mx_out}, 2);
    wait_end(30);
    chk(done_seen && !abort_seen, "R7 single byte done", done_seen, 1);
    chk(done_fr - rise_fr == 2, "R7 two release frames", done_fr - rise_fr, 2);
    chk(!busy && mx_out, "R7 idle after end", busy, 0);
    chk(exp_q.size() == 0, "R3 all bytes sent", exp_q.size(), 0);
    flush();
    repeat (3) @(fr_ev);

    // R4 R9: three bytes, slow receiver, next byte always ready
    ack_delay = 3;
    send_msg(3, 8'h11, 8'h22, 8'h33);
    wait_end(80);
    chk(done_seen && !abort_seen, "R7 three byte done", done_seen, 1);
    chk(exp_q.size() == 0, "R3 three bytes sent", exp_q.size(), 0);
    flush();
    repeat (3) @(fr_ev);

    // R8: source stalls after the first byte
    ack_delay = 2; chk_antic = 0; src_limit = 1;
    send_msg(2, 8'h5C, 8'hC5, 8'h00);
    wait_gap(20);
    repeat (4) @(fr_ev);
    chk(mx_out && busy && !done_seen, "R8 stalled wait", {mx_out, busy, done_seen}, 6);
    src_limit = 99;
    wait_end(40);
    chk(done_seen && exp_q.size() == 0, "R8 resumes after stall", done_seen, 1);
    flush(); chk_antic = 1;
    repeat (3) @(fr_ev);

    // R10: acknowledge in the first frame of a byte
    ack_delay = 1; chk_len = 0; chk_antic = 0;
    send_msg(2, 8'h3C, 8'hC3, 8'h00);
    wait_end(20);
    chk(abort_seen && !done_seen, "R10 early ack aborts", abort_seen, 1);
    repeat (2) @(fr_ev);
    chk(!busy && mx_out, "R6 back to idle after abort", busy, 0);
    flush(); ack_delay = 2;
    repeat (3) @(fr_ev);

    // R5: collision while MX is released between bytes
    send_msg(2, 8'h69, 8'h96, 8'h00);
    wait_gap(20);
    other_mx = 1'b0;
    @(fr_ev);
    other_mx = 1'b1;
    chk(abort_seen && mx_out, "R5 collision aborts", {abort_seen, mx_out}, 3);
    repeat (2) @(fr_ev);
    chk(!busy, "R5 recovers to idle", busy, 0);
    flush();
    repeat (3) @(fr_ev);

    // R6: local abort request during a byte
    ack_delay = 6;
    send_msg(3, 8'h01, 8'h02, 8'h03);
    for (int i = 0; i < 20; i++) begin
      if (busy && !mx_out) break;
      @(fr_ev);
    end
    @(fr_ev);
    abort_req = 1'b1;
    @(fr_ev);
    abort_req = 1'b0;
    chk(abort_seen && mx_out && !done_seen, "R6 abort request", {abort_seen, mx_out}, 3);
    repeat (2) @(fr_ev);
    flush(); ack_delay = 2;
    repeat (3) @(fr_ev);

    // R6: abort request ignored when idle
    abort_seen = 0;
    abort_req = 1'b1;
    repeat (2) @(fr_ev);
    abort_req = 1'b0;
    chk(!abort_seen && !busy && mx_out, "R6 idle abort ignored", abort_seen, 0);

    // recovery: normal message after the aborts
    chk_len = 1; chk_antic = 1;
    send_msg(2, 8'hE7, 8'h7E, 8'h00);
    wait_end(40);
    chk(done_seen && exp_q.size() == 0, "R3 message after aborts", done_seen, 1);
    flush();
    repeat (2) @(fr_ev);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule